// File: doc/BRIEF.md
# USB Root Hub Port Status and Command Register

This block is the status and command word for one downstream port of a full-speed USB root hub. A read returns the live condition of the port: whether a device is attached, whether the port is enabled, suspended, in over-current, being reset or powered, and whether the attached device is low-speed. A write uses the same low bit positions as one-shot commands. A 1 in a command bit acts and a 0 does nothing, so software can issue one command without first reading the word back. Five sticky change flags in the upper half record port events until software clears them by writing 1.

The port side supplies three indications: device attached, over-current and low-speed. They are registered before use. Two sequences are timed inside the block. A port reset holds the reset bit for a parameterised number of cycles and then enables the port. A resume started from suspend runs for a fixed number of cycles before the suspend bit drops. Line signalling and hub-wide power control live elsewhere.

Top module: `rh_port_status`

## Requirements
- R1: After reset, with all port inputs low, the read word is 0.
- R2: Bit 0 reads the attach input, bit 3 the over-current input and bit 9 the low-speed input, each one clock after the input changes.
- R3: A written 0 in any bit has no effect. While bit 8 reads 0 (unpowered), every command other than set-power (bit 8) is ignored; the change-flag clears still work.
- R4: Writing 1 to bit 8 powers the port. Writing 1 to bit 9 unpowers it and clears enable, suspend and reset, setting bit 17 if the port was enabled.
- R5: Writing 1 to bit 1 enables the port if a device is attached; otherwise the port stays disabled and bit 16 is set. Writing 1 to bit 0 disables the port without setting bit 17.
- R6: Writing 1 to bit 4 with a device attached makes bit 4 read 1 for exactly RESET_CYCLES cycles. The port then becomes enabled and bit 20 is set. With no device attached, bit 16 is set instead. A detach, over-current or power-off ends the reset early without setting bit 20.
- R7: Writing 1 to bit 2 suspends an enabled port that is not in reset. Writing 1 to bit 3 on a suspended port starts a resume: bit 2 stays 1 for RESUME_CYCLES more cycles, then reads 0, and bit 18 is set.
- R8: A change of the attach input sets bit 16, and a change of the over-current input sets bit 19. An attach change, or the over-current input being high, disables the port and sets bit 17 if it was enabled. The port is never enabled while over-current or detached.
- R9: Bits 16 to 20 (attach, enable, suspend, over-current and reset-done change) are cleared by writing 1 to them. An event that sets a flag in the same cycle as its clear wins.
- R10: Bits 5 to 7, 10 to 15 and 21 to 31 always read 0, and writing them has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_data | input | 32 | Command and flag-clear bits |
| rd_data | output | 32 | Live status and change flags |
| dev_conn_i | input | 1 | Device attached |
| dev_oc_i | input | 1 | Over-current indication |
| dev_ls_i | input | 1 | Low-speed device indication |

## Verification
The assertions assume that the three port inputs are synchronous to clk and stable around the rising edge, and that each write lasts a single cycle. The bench drives every input, the strobe included, only on the falling edge, and drops the strobe after one cycle. The invariants the assertions check are meant to hold for any order of inputs: enable only while attached, powered and free of over-current, suspend only while enabled. The stimulus therefore deliberately sends detach and over-current during reset, enable and resume, and sends commands while the port is unpowered.

// File: rtl/rh_port_pkg.sv
package rh_port_pkg;

  // Bit positions shared by the read and write views of the port word.
  localparam int B_CONN_CLREN  = 0;
  localparam int B_EN_SETEN    = 1;
  localparam int B_SUSP_SETSUS = 2;
  localparam int B_OC_CLRSUS   = 3;
  localparam int B_RST_SETRST  = 4;
  localparam int B_PWR_SETPWR  = 8;
  localparam int B_LS_CLRPWR   = 9;

  localparam int FLAG_N   = 5;
  localparam int FLAG_LSB = 16;

  // Index of each sticky flag inside the flag field.
  localparam int FL_CONN = 0;
  localparam int FL_EN   = 1;
  localparam int FL_SUSP = 2;
  localparam int FL_OC   = 3;
  localparam int FL_RST  = 4;

  typedef struct packed {
    logic clr_pwr;
    logic set_pwr;
    logic set_rst;
    logic clr_susp;
    logic set_susp;
    logic set_en;
    logic clr_en;
  } port_cmd_t;

endpackage

// File: rtl/rh_port_timer.sv
module rh_port_timer #(
  parameter int CYCLES = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic active,
  output logic done
);

  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          act_q, act_n;
  logic          tick;

  always_comb begin
    cnt_n = cnt_q;
    act_n = act_q;
    done  = act_q & (cnt_q == '0) & ~abort;
    if (abort) begin
      act_n = 1'b0;
      cnt_n = '0;
    end else if (act_q) begin
      if (cnt_q == '0) act_n = 1'b0;
      else             cnt_n = cnt_q - 1'b1;
    end else if (start) begin
      act_n = 1'b1;
      cnt_n = LOAD;
    end
  end

  assign tick = abort | act_q | start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (tick) begin
      act_q <= act_n;
      cnt_q <= cnt_n;
    end
  end

  assign active = act_q;

  // R6 / R7: a finishing count releases the sequence on the next cycle.
  a_r6_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !active);
  // R6 / R7: an accepted start is visible one cycle later.
  a_r7_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !abort && !active) |=> active);

endmodule

// File: rtl/rh_port_chg_flags.sv
module rh_port_chg_flags #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);

  for (genvar g = 0; g < N; g++) begin : g_flag
    logic q, d, we;

    always_comb begin
      we = set_i[g] | clr_i[g];
      d  = set_i[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= 1'b0;
      else if (we) q <= d;
    end

    assign flags_o[g] = q;

    // R9: a set event beats a clear in the same cycle.
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> flags_o[g]);
    // R9: writing 1 clears the flag when no event arrives.
    a_r9_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !set_i[g]) |=> !flags_o[g]);
  end

endmodule

// File: rtl/rh_port_ctrl.sv
module rh_port_ctrl
  import rh_port_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  port_cmd_t cmd,
  input  logic      conn_q,
  input  logic      conn_chg,
  input  logic      oc_now,
  input  logic      rst_active,
  input  logic      rst_done,
  input  logic      rsm_active,
  input  logic      rsm_done,
  output logic      powered,
  output logic      enabled,
  output logic      suspended,
  output logic      rst_start,
  output logic      rst_abort,
  output logic      rsm_start,
  output logic      rsm_abort,
  output logic      pesc_set,
  output logic      csc_cmd
);

  logic pwr_q, pwr_n, pwr_we;
  logic en_q, en_n;
  logic sus_q, sus_n;
  logic live, kill, sw_disable;

  always_comb begin
    live       = pwr_q;
    kill       = (live & cmd.clr_pwr) | conn_chg | oc_now;
    sw_disable = live & cmd.clr_en;

    rst_start = live & cmd.set_rst & conn_q & ~rst_active & ~kill;
    rst_abort = kill;
    rsm_abort = kill | sw_disable | rst_start;
    rsm_start = live & cmd.clr_susp & sus_q & ~rsm_active & ~rsm_abort;

    // Power: set is always honoured, clear only counts while powered.
    pwr_we = cmd.set_pwr | (live & cmd.clr_pwr);
    pwr_n  = ~(live & cmd.clr_pwr);

    // Enable: set, then software clear, then reset completion, then hardware kill.
    en_n = en_q;
    if (live & cmd.set_en & conn_q) en_n = 1'b1;
    if (sw_disable)                 en_n = 1'b0;
    if (rst_done)                   en_n = 1'b1;
    if (kill)                       en_n = 1'b0;

    // Suspend follows enable down and drops when a resume finishes.
    sus_n = sus_q;
    if (live & cmd.set_susp & en_q & ~rst_active) sus_n = 1'b1;
    if (rsm_done)                                 sus_n = 1'b0;
    if (rsm_abort)                                sus_n = 1'b0;

    pesc_set = en_q & kill;
    csc_cmd  = live & ~conn_q & (cmd.set_en | cmd.set_rst);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pwr_q <= 1'b0;
    else if (pwr_we) pwr_q <= pwr_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sus_q <= 1'b0;
    end else begin
      en_q  <= en_n;
      sus_q <= sus_n;
    end
  end

  assign powered   = pwr_q;
  assign enabled   = en_q;
  assign suspended = sus_q;

  // R7: suspend only exists on an enabled port.
  a_r7_susp_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    sus_q |-> en_q);
  // R4: an unpowered port is idle.
  a_r4_unpowered_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_q |-> (!en_q && !rst_active && !rsm_active));
  // R6: reset completion always leaves the port enabled.
  a_r6_done_enables: assert property (@(posedge clk) disable iff (!rst_n)
    rst_done |=> en_q);

endmodule

// File: rtl/rh_port_status.sv
module rh_port_status
  import rh_port_pkg::*;
#(
  parameter int RESET_CYCLES  = 10,
  parameter int RESUME_CYCLES = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic        dev_conn_i,
  input  logic        dev_oc_i,
  input  logic        dev_ls_i
);

  logic conn_q, oc_q, ls_q;
  logic conn_chg, oc_chg;
  port_cmd_t cmd;
  logic [FLAG_N-1:0] flag_set, flag_clr, flags;

  logic powered, enabled, suspended;
  logic rst_start, rst_abort, rst_active, rst_done;
  logic rsm_start, rsm_abort, rsm_active, rsm_done;
  logic pesc_set, csc_cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conn_q <= 1'b0;
      oc_q   <= 1'b0;
      ls_q   <= 1'b0;
    end else begin
      conn_q <= dev_conn_i;
      oc_q   <= dev_oc_i;
      ls_q   <= dev_ls_i;
    end
  end

  always_comb begin
    conn_chg     = dev_conn_i ^ conn_q;
    oc_chg       = dev_oc_i ^ oc_q;
    cmd.clr_en   = wr_en & wr_data[B_CONN_CLREN];
    cmd.set_en   = wr_en & wr_data[B_EN_SETEN];
    cmd.set_susp = wr_en & wr_data[B_SUSP_SETSUS];
    cmd.clr_susp = wr_en & wr_data[B_OC_CLRSUS];
    cmd.set_rst  = wr_en & wr_data[B_RST_SETRST];
    cmd.set_pwr  = wr_en & wr_data[B_PWR_SETPWR];
    cmd.clr_pwr  = wr_en & wr_data[B_LS_CLRPWR];
    flag_clr     = wr_en ? wr_data[FLAG_LSB +: FLAG_N] : '0;
    flag_set          = '0;
    flag_set[FL_CONN] = conn_chg | csc_cmd;
    flag_set[FL_EN]   = pesc_set;
    flag_set[FL_SUSP] = rsm_done;
    flag_set[FL_OC]   = oc_chg;
    flag_set[FL_RST]  = rst_done;
  end

  rh_port_ctrl i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd        (cmd),
    .conn_q     (conn_q),
    .conn_chg   (conn_chg),
    .oc_now     (dev_oc_i),
    .rst_active (rst_active),
    .rst_done   (rst_done),
    .rsm_active (rsm_active),
    .rsm_done   (rsm_done),
    .powered    (powered),
    .enabled    (enabled),
    .suspended  (suspended),
    .rst_start  (rst_start),
    .rst_abort  (rst_abort),
    .rsm_start  (rsm_start),
    .rsm_abort  (rsm_abort),
    .pesc_set   (pesc_set),
    .csc_cmd    (csc_cmd)
  );

  rh_port_timer #(.CYCLES(RESET_CYCLES)) i_rst_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (rst_start),
    .abort  (rst_abort),
    .active (rst_active),
    .done   (rst_done)
  );

  rh_port_timer #(.CYCLES(RESUME_CYCLES)) i_rsm_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (rsm_start),
    .abort  (rsm_abort),
    .active (rsm_active),
    .done   (rsm_done)
  );

  rh_port_chg_flags #(.N(FLAG_N)) i_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (flag_set),
    .clr_i   (flag_clr),
    .flags_o (flags)
  );

  always_comb begin
    rd_data                        = '0;
    rd_data[B_CONN_CLREN]          = conn_q;
    rd_data[B_EN_SETEN]            = enabled;
    rd_data[B_SUSP_SETSUS]         = suspended;
    rd_data[B_OC_CLRSUS]           = oc_q;
    rd_data[B_RST_SETRST]          = rst_active;
    rd_data[B_PWR_SETPWR]          = powered;
    rd_data[B_LS_CLRPWR]           = ls_q;
    rd_data[FLAG_LSB +: FLAG_N]    = flags;
  end

  // Checker-only delayed copy of the attach state.
  logic conn_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) conn_d <= 1'b0;
    else        conn_d <= conn_q;
  end

  // R5 / R8: enable implies an attached device.
  a_r5_en_needs_conn: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[B_EN_SETEN] |-> rd_data[B_CONN_CLREN]);
  // R8: never enabled while over-current is reported.
  a_r8_en_not_oc: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[B_EN_SETEN] |-> !rd_data[B_OC_CLRSUS]);
  // R8: a seen attach change has its flag raised.
  a_r8_conn_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (conn_q != conn_d) |-> rd_data[FLAG_LSB + FL_CONN]);
  // R6: a reset only runs on a powered port.
  a_r6_reset_powered: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[B_RST_SETRST] |-> rd_data[B_PWR_SETPWR]);

endmodule

// File: tb/test_rh_port_status.sv
module test_rh_port_status;

  localparam int RST_N_CYC = 10;
  localparam int RSM_N_CYC = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        conn_in = 1'b0;
  logic        oc_in = 1'b0;
  logic        ls_in = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rh_port_status #(.RESET_CYCLES(RST_N_CYC), .RESUME_CYCLES(RSM_N_CYC)) i_rh_port_status (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .dev_conn_i(conn_in), .dev_oc_i(oc_in), .dev_ls_i(ls_in)
  );

  // Behavioural reference state.
  bit m_conn, m_oc, m_ls, m_en, m_susp, m_pwr;
  int rst_left, rsm_left;
  bit m_flag[5];

  function automatic logic [31:0] model_word();
    logic [31:0] v = '0;
    v[0] = m_conn; v[1] = m_en; v[2] = m_susp; v[3] = m_oc;
    v[4] = (rst_left > 0); v[8] = m_pwr; v[9] = m_ls;
    for (int i = 0; i < 5; i++) v[16+i] = m_flag[i];
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_conn = 0; m_oc = 0; m_ls = 0; m_en = 0; m_susp = 0; m_pwr = 0;
      rst_left = 0; rsm_left = 0;
      for (int i = 0; i < 5; i++) m_flag[i] = 0;
    end else begin
      logic [31:0] w;
      bit on, cc, occ, kill, start_rst, start_rsm, rsm_kill, rst_fin, rsm_fin;
      bit e, s, p;
      bit fset[5];
      int nr, nm;
      w   = wr_en ? wr_data : 32'h0;
      on  = m_pwr;
      cc  = (conn_in != m_conn);
      occ = (oc_in != m_oc);
      kill = (on && w[9]) || cc || oc_in;
      start_rst = on && w[4] && m_conn && rst_left == 0 && !kill;
      rsm_kill  = kill || (on && w[0]) || start_rst;
      rst_fin = 0; rsm_fin = 0;
      nr = rst_left;
      if (rst_left > 0) begin
        if (kill) nr = 0;
        else begin nr = rst_left - 1; rst_fin = (nr == 0); end
      end else if (start_rst) nr = RST_N_CYC;
      start_rsm = on && w[3] && m_susp && rsm_left == 0 && !rsm_kill;
      nm = rsm_left;
      if (rsm_left > 0) begin
        if (rsm_kill) nm = 0;
        else begin nm = rsm_left - 1; rsm_fin = (nm == 0); end
      end else if (start_rsm) nm = RSM_N_CYC;
      e = m_en;
      if (on && w[1] && m_conn) e = 1;
      if (on && w[0]) e = 0;
      if (rst_fin) e = 1;
      if (kill) e = 0;
      s = m_susp;
      if (on && w[2] && m_en && rst_left == 0) s = 1;
      if (rsm_fin) s = 0;
      if (rsm_kill) s = 0;
      p = m_pwr;
      if (w[8]) p = 1;
      if (on && w[9]) p = 0;
      fset[0] = cc || (on && !m_conn && (w[1] || w[4]));
      fset[1] = m_en && kill;
      fset[2] = rsm_fin;
      fset[3] = occ;
      fset[4] = rst_fin;
      for (int i = 0; i < 5; i++)
        m_flag[i] = fset[i] ? 1'b1 : (w[16+i] ? 1'b0 : m_flag[i]);
      m_en = e; m_susp = s; m_pwr = p; rst_left = nr; rsm_left = nm;
      m_conn = conn_in; m_oc = oc_in; m_ls = ls_in;
    end
  end

  function automatic string tag_of(logic [31:0] diff);
    if (diff[0] || diff[3] || diff[9]) return "R2";
    if (diff[1]) return "R5";
    if (diff[2]) return "R7";
    if (diff[4]) return "R6";
    if (diff[8]) return "R4";
    if (|diff[20:16]) return "R9";
    return "R10";
  endfunction

  // Cycle-by-cycle comparison against the reference, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [31:0] exp_w;
      exp_w = model_word();
      n_cmp++;
      if (rd_data !== exp_w) begin
        n_bad++;
        $display("FAIL %s model compare: actual %h expected %h at %0t",
                 tag_of(rd_data ^ exp_w), rd_data, exp_w, $time);
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp_v);
    n_cmp++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
    end
  endtask

  task automatic wr(logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    idle(1);
    check("R1 reset word", rd_data, 32'h0);

    wr(32'h2);  check("R3 enable while unpowered", rd_data, 32'h0);
    wr(32'h0);  check("R3 zero write", rd_data, 32'h0);
    wr(32'h100); check("R4 set power", rd_data, 32'h100);
    wr(32'h2);  check("R5 enable with no device", rd_data, 32'h10100);
    wr(32'h10000); check("R9 clear attach flag", rd_data, 32'h100);

    @(negedge clk); conn_in = 1'b1; ls_in = 1'b1;
    @(negedge clk); check("R2 R8 attach seen", rd_data, 32'h10301);
    wr(32'h10000); check("R9 clear", rd_data, 32'h301);

    wr(32'h2);  check("R5 enable", rd_data, 32'h303);
    wr(32'h1);  check("R5 software disable no flag", rd_data, 32'h301);

    wr(32'h10); check("R6 reset begins", rd_data, 32'h311);
    idle(RST_N_CYC - 1); check("R6 reset still active", rd_data[4], 1'b1);
    idle(1);    check("R6 reset done", rd_data, 32'h100303);
    wr(32'h100000); check("R9 clear reset flag", rd_data, 32'h303);

    wr(32'h4);  check("R7 suspend", rd_data, 32'h307);
    wr(32'h8);  check("R7 resume started", rd_data[2], 1'b1);
    idle(RSM_N_CYC - 1); check("R7 resume ongoing", rd_data[2], 1'b1);
    idle(1);    check("R7 resume done", rd_data, 32'h40303);
    wr(32'h40000); check("R9 clear suspend flag", rd_data, 32'h303);

    @(negedge clk); oc_in = 1'b1;
    @(negedge clk); check("R8 over-current disables", rd_data, 32'hA0309);
    @(negedge clk); wr_en = 1'b1; wr_data = 32'h1F0000; oc_in = 1'b0;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
    check("R9 event beats clear", rd_data, 32'h80301);
    wr(32'h80000); check("R9 clear oc flag", rd_data, 32'h301);

    wr(32'h2);   check("R5 re-enable", rd_data, 32'h303);
    wr(32'h200); check("R4 power off", rd_data, 32'h20201);
    wr(32'h2);   check("R3 enable ignored unpowered", rd_data, 32'h20201);
    wr(32'h20000); check("R9 clear works unpowered", rd_data, 32'h201);
    wr(32'h10);  check("R3 reset ignored unpowered", rd_data, 32'h201);

    wr(32'h100); wr(32'h2);
    check("R5 enable again", rd_data, 32'h303);
    @(negedge clk); conn_in = 1'b0; ls_in = 1'b0;
    @(negedge clk); check("R8 detach disables", rd_data, 32'h30100);
    wr(32'h30000); check("R9 clear two flags", rd_data, 32'h100);

    wr(32'h10); check("R6 reset with no device", rd_data, 32'h10100);
    wr(32'h10000);
    @(negedge clk); conn_in = 1'b1;
    @(negedge clk); wr(32'h10000);
    check("R2 attach again", rd_data, 32'h101);
    wr(32'h10); idle(3);
    @(negedge clk); conn_in = 1'b0;
    @(negedge clk); check("R6 reset aborted by detach", rd_data, 32'h10100);
    wr(32'h10000);

    wr(32'hFFE0FCE0); check("R10 reserved bits", rd_data, 32'h100);
    idle(4);
    check("R10 reserved read zero", rd_data & 32'hFFE0FCE0, 32'h0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule